// File: doc/BRIEF.md
# Dual-Segment Base-and-Bound Address Translator

This block turns logical addresses into physical ones for two independent memory segments: one serves instruction fetch, the other serves data loads and stores. Each segment owns a base register and a bound register. A logical address is checked against its segment's bound. When it is in range, the physical address is the sum of the base and the logical address. When it is out of range, the access is refused and a violation is recorded.

Both channels are purely combinational from address to physical address and access-valid. The violation flags come from registers and appear one clock after the offending access. The four registers are loaded through a single register-write port. Only a write issued in supervisor mode changes them. A write attempted in user mode is dropped and produces a one-cycle privilege-error pulse. After reset every register holds zero, so every access faults until supervisor software has set up the segments.

Top module: `dual_seg_xlate`

## Requirements
- R1: When a channel's access valid is high and its logical address is strictly below that segment's bound, access-ok is high and the physical address equals base plus logical address, taken modulo 2^32, in the same cycle.
- R2: When the logical address is greater than or equal to the bound, the physical address output is zero and access-ok is low. Access-ok is also low whenever access valid is low.
- R3: A channel's fault output is high in the cycle after a valid access whose address is greater than or equal to the bound. It is low in the cycle after any other access, including one with valid low.
- R4: The fetch channel uses only the program base and bound, and the data channel uses only the data base and bound. The two checks are independent of each other.
- R5: A write with supervisor mode high loads the data value into the register chosen by the 2-bit select: 0 = program base, 1 = program bound, 2 = data base, 3 = data bound. The new value takes effect from the next cycle.
- R6: A write with supervisor mode low changes no register, and the privilege-error output is high for exactly the one cycle after it. The privilege-error output is low after every other cycle.
- R7: Reset clears all four registers to zero, so every valid access faults. Reset also clears both fault outputs and the privilege-error output.
- R8: When both channels violate their bounds in the same cycle, both fault outputs rise together in the next cycle, and neither suppresses the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| supMode | input | 1 | High while the processor runs in supervisor mode |
| regWrEn | input | 1 | Register write request |
| regWrSel | input | 2 | Target register select (0 prog base, 1 prog bound, 2 data base, 3 data bound) |
| regWrData | input | 32 | Value to write |
| fetchValid | input | 1 | Instruction fetch access present |
| fetchAddr | input | 32 | Fetch logical address |
| fetchPhys | output | 32 | Fetch physical address, zero on violation |
| fetchOk | output | 1 | Fetch access allowed |
| fetchFault | output | 1 | Registered fetch bound violation |
| dataValid | input | 1 | Data access present |
| dataAddr | input | 32 | Data logical address |
| dataPhys | output | 32 | Data physical address, zero on violation |
| dataOk | output | 1 | Data access allowed |
| dataFault | output | 1 | Registered data bound violation |
| privErr | output | 1 | One-cycle pulse after a user-mode register write |

## Verification
Random addresses are drawn partly from the full 32-bit range and partly from within a few units of the active bound. This separates a correct greater-or-equal compare from an off-by-one or a strict compare. Bases close to 2^32 show whether the sum wraps instead of saturating. The program and data segments get deliberately different values, so a channel that reads the wrong pair shows up at once. Randomly mixed user-mode writes, each followed by accesses that probe the registers, show that a dropped write really leaves the translation unchanged.

// File: rtl/xlate_pkg.sv
`timescale 1ns/1ps
package xlate_pkg;

  localparam int SEL_W   = 2;
  localparam int NUM_SEG = 2;
  localparam int NUM_REG = 2 * NUM_SEG;

  // register index = segment * 2 + (0 base / 1 bound)
  typedef enum logic [SEL_W-1:0] {
    SEL_PRG_BASE  = 2'd0,
    SEL_PRG_BOUND = 2'd1,
    SEL_DAT_BASE  = 2'd2,
    SEL_DAT_BOUND = 2'd3
  } regSel_e;

  typedef struct packed {
    logic [NUM_REG-1:0] wrStrobe;
    logic               userWr;
  } ctrlStrobes_t;

endpackage

// File: rtl/xlate_ctrl.sv
`timescale 1ns/1ps
module xlate_ctrl
  import xlate_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                supMode,
  input  logic                regWrEn,
  input  logic [SEL_W-1:0]    regWrSel,
  output ctrlStrobes_t        strobes,
  output logic                privErr
);

  always_comb begin
    strobes.wrStrobe = '0;
    strobes.userWr   = regWrEn & ~supMode;
    if (regWrEn && supMode) begin
      strobes.wrStrobe[regWrSel] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      privErr <= 1'b0;
    end else begin
      privErr <= strobes.userWr;
    end
  end

endmodule

// File: rtl/seg_chan.sv
`timescale 1ns/1ps
module seg_chan #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] boundVal,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  output logic [ADDR_W-1:0] physAddr,
  output logic              accOk,
  output logic              faultQ
);

  logic viol;

  always_comb begin
    viol     = (accAddr >= boundVal);
    physAddr = viol ? '0 : (baseVal + accAddr);
    accOk    = accValid & ~viol;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultQ <= 1'b0;
    end else begin
      faultQ <= accValid & viol;
    end
  end

endmodule

// File: rtl/xlate_dp.sv
`timescale 1ns/1ps
module xlate_dp
  import xlate_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  ctrlStrobes_t                    strobes,
  input  logic [ADDR_W-1:0]               wrData,
  input  logic [NUM_SEG-1:0]              accValid,
  input  logic [NUM_SEG-1:0][ADDR_W-1:0]  accAddr,
  output logic [NUM_SEG-1:0][ADDR_W-1:0]  physAddr,
  output logic [NUM_SEG-1:0]              accOk,
  output logic [NUM_SEG-1:0]              faultQ
);

  logic [NUM_SEG-1:0][ADDR_W-1:0] baseQ;
  logic [NUM_SEG-1:0][ADDR_W-1:0] boundQ;

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseQ[s]  <= '0;
        boundQ[s] <= '0;
      end else begin
        if (strobes.wrStrobe[2*s])   baseQ[s]  <= wrData;
        if (strobes.wrStrobe[2*s+1]) boundQ[s] <= wrData;
      end
    end

    seg_chan #(.ADDR_W(ADDR_W)) u_chan (
      .clk      (clk),
      .rstN     (rstN),
      .baseVal  (baseQ[s]),
      .boundVal (boundQ[s]),
      .accValid (accValid[s]),
      .accAddr  (accAddr[s]),
      .physAddr (physAddr[s]),
      .accOk    (accOk[s]),
      .faultQ   (faultQ[s])
    );
  end

endmodule

// File: rtl/dual_seg_xlate.sv
`timescale 1ns/1ps
module dual_seg_xlate
  import xlate_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              supMode,
  input  logic              regWrEn,
  input  logic [SEL_W-1:0]  regWrSel,
  input  logic [ADDR_W-1:0] regWrData,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic [ADDR_W-1:0] fetchPhys,
  output logic              fetchOk,
  output logic              fetchFault,
  input  logic              dataValid,
  input  logic [ADDR_W-1:0] dataAddr,
  output logic [ADDR_W-1:0] dataPhys,
  output logic              dataOk,
  output logic              dataFault,
  output logic              privErr
);

  localparam int SEG_PRG = 0;
  localparam int SEG_DAT = 1;

  ctrlStrobes_t                   strobes;
  logic [NUM_SEG-1:0]             accValid;
  logic [NUM_SEG-1:0][ADDR_W-1:0] accAddr;
  logic [NUM_SEG-1:0][ADDR_W-1:0] physAddr;
  logic [NUM_SEG-1:0]             accOk;
  logic [NUM_SEG-1:0]             faultQ;

  assign accValid[SEG_PRG] = fetchValid;
  assign accValid[SEG_DAT] = dataValid;
  assign accAddr[SEG_PRG]  = fetchAddr;
  assign accAddr[SEG_DAT]  = dataAddr;

  xlate_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .supMode  (supMode),
    .regWrEn  (regWrEn),
    .regWrSel (regWrSel),
    .strobes  (strobes),
    .privErr  (privErr)
  );

  xlate_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrData   (regWrData),
    .accValid (accValid),
    .accAddr  (accAddr),
    .physAddr (physAddr),
    .accOk    (accOk),
    .faultQ   (faultQ)
  );

  assign fetchPhys  = physAddr[SEG_PRG];
  assign fetchOk    = accOk[SEG_PRG];
  assign fetchFault = faultQ[SEG_PRG];
  assign dataPhys   = physAddr[SEG_DAT];
  assign dataOk     = accOk[SEG_DAT];
  assign dataFault  = faultQ[SEG_DAT];

endmodule

// File: rtl/xlate_checker.sv
`timescale 1ns/1ps
module xlate_checker #(
  parameter int ADDR_W = 32
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  supMode,
  input logic                  regWrEn,
  input logic                  fetchValid,
  input logic [ADDR_W-1:0]     fetchPhys,
  input logic                  fetchOk,
  input logic                  fetchFault,
  input logic                  dataValid,
  input logic [ADDR_W-1:0]     dataPhys,
  input logic                  dataOk,
  input logic                  dataFault,
  input logic                  privErr,
  input logic [2*ADDR_W-1:0]   baseRegs,
  input logic [2*ADDR_W-1:0]   boundRegs
);

  p_fetch_ok_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    fetchOk |-> fetchValid);
  p_data_ok_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    dataOk |-> dataValid);
  p_fetch_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && !fetchOk) |-> (fetchPhys == '0));
  p_data_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && !dataOk) |-> (dataPhys == '0));
  p_fetch_fault_r3: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && !fetchOk) |=> fetchFault);
  p_fetch_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(fetchValid && !fetchOk) |=> !fetchFault);
  p_both_fault_r8: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && !fetchOk && dataValid && !dataOk) |=> (fetchFault && dataFault));
  p_data_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(dataValid && !dataOk) |=> !dataFault);
  p_priv_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !supMode) |=> privErr);
  p_priv_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && !supMode) |=> !privErr);
  p_user_ignored_r6: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !supMode) |=> ($stable(baseRegs) && $stable(boundRegs)));
  p_no_write_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> ($stable(baseRegs) && $stable(boundRegs)));

endmodule

bind dual_seg_xlate xlate_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .supMode    (supMode),
  .regWrEn    (regWrEn),
  .fetchValid (fetchValid),
  .fetchPhys  (fetchPhys),
  .fetchOk    (fetchOk),
  .fetchFault (fetchFault),
  .dataValid  (dataValid),
  .dataPhys   (dataPhys),
  .dataOk     (dataOk),
  .dataFault  (dataFault),
  .privErr    (privErr),
  .baseRegs   (u_dp.baseQ),
  .boundRegs  (u_dp.boundQ)
);

// File: tb/dual_seg_xlate_tb_top.sv
`timescale 1ns/1ps
module dual_seg_xlate_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        supMode = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regWrSel = '0;
  logic [31:0] regWrData = '0;
  logic        fetchValid = 1'b0;
  logic [31:0] fetchAddr = '0;
  logic [31:0] fetchPhys;
  logic        fetchOk;
  logic        fetchFault;
  logic        dataValid = 1'b0;
  logic [31:0] dataAddr = '0;
  logic [31:0] dataPhys;
  logic        dataOk;
  logic        dataFault;
  logic        privErr;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit done = 0;

  // bench model: index 0 prog base, 1 prog bound, 2 data base, 3 data bound
  logic [31:0] mReg [4];

  always #4 clk = ~clk;  // 125 MHz

  dual_seg_xlate dut_i (
    .clk(clk), .rstN(rstN), .supMode(supMode), .regWrEn(regWrEn),
    .regWrSel(regWrSel), .regWrData(regWrData),
    .fetchValid(fetchValid), .fetchAddr(fetchAddr), .fetchPhys(fetchPhys),
    .fetchOk(fetchOk), .fetchFault(fetchFault),
    .dataValid(dataValid), .dataAddr(dataAddr), .dataPhys(dataPhys),
    .dataOk(dataOk), .dataFault(dataFault), .privErr(privErr)
  );

  function automatic logic expViol(input logic [31:0] a, input logic [31:0] bnd);
    return a >= bnd;
  endfunction

  function automatic logic [31:0] expPhys(input logic [31:0] a, input logic [31:0] b,
                                          input logic [31:0] bnd);
    return (a >= bnd) ? 32'd0 : b + a;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check combinational outputs, then registered ones
  task automatic step(input string scen, input logic sup, input logic wr,
                      input logic [1:0] sel, input logic [31:0] wd,
                      input logic fv, input logic [31:0] fa,
                      input logic dv, input logic [31:0] da);
    logic eF, eD;
    @(negedge clk);
    supMode = sup; regWrEn = wr; regWrSel = sel; regWrData = wd;
    fetchValid = fv; fetchAddr = fa; dataValid = dv; dataAddr = da;
    #1;
    eF = fv && expViol(fa, mReg[1]);
    eD = dv && expViol(da, mReg[3]);
    // R1 / R2 / R4: fetch uses program pair, data uses data pair
    check({scen, " R1"}, "fetchPhys", fetchPhys, expPhys(fa, mReg[0], mReg[1]));
    check({scen, " R2"}, "fetchOk", {31'd0, fetchOk}, {31'd0, fv && !expViol(fa, mReg[1])});
    check({scen, " R4"}, "dataPhys", dataPhys, expPhys(da, mReg[2], mReg[3]));
    check({scen, " R2"}, "dataOk", {31'd0, dataOk}, {31'd0, dv && !expViol(da, mReg[3])});
    @(posedge clk);
    #1;
    check({scen, " R3"}, "fetchFault", {31'd0, fetchFault}, {31'd0, eF});
    check({scen, " R3"}, "dataFault", {31'd0, dataFault}, {31'd0, eD});
    check({scen, " R6"}, "privErr", {31'd0, privErr}, {31'd0, wr && !sup});
    if (wr && sup) mReg[sel] = wd;  // R5: visible from next cycle
  endtask

  task automatic idle();
    step("idle", 1'b0, 1'b0, 2'd0, 32'd0, 1'b0, 32'd0, 1'b0, 32'd0);
  endtask

  initial begin
    process::self().srandom(32'd20240917);
    for (int i = 0; i < 4; i++) mReg[i] = '0;
    repeat (3) @(negedge clk);
    // R7: reset state
    #1;
    check("R7", "fetchFault in reset", {31'd0, fetchFault}, 32'd0);
    check("R7", "privErr in reset", {31'd0, privErr}, 32'd0);
    rstN = 1'b1;
    // R7: zero bounds fault every access, both at once (R8)
    step("R7", 1'b1, 1'b0, 2'd0, 0, 1'b1, 32'd0, 1'b1, 32'd0);
    step("R8", 1'b1, 1'b0, 2'd0, 0, 1'b1, 32'hFFFF_FFFF, 1'b1, 32'h10);
    // R5: load all four registers, each distinct
    step("R5", 1'b1, 1'b1, 2'd0, 32'h0001_0000, 1'b0, 0, 1'b0, 0);
    step("R5", 1'b1, 1'b1, 2'd1, 32'h0000_1000, 1'b1, 32'h20, 1'b0, 0);
    step("R5", 1'b1, 1'b1, 2'd2, 32'hFFFF_F000, 1'b1, 32'h20, 1'b1, 32'h4);
    step("R5", 1'b1, 1'b1, 2'd3, 32'h0000_2000, 1'b1, 32'h20, 1'b1, 32'h4);
    // R1 boundary: bound-1 passes, bound faults; data base wraps
    step("R1", 1'b1, 1'b0, 2'd0, 0, 1'b1, 32'h0FFF, 1'b1, 32'h1FFF);
    step("R2", 1'b1, 1'b0, 2'd0, 0, 1'b1, 32'h1000, 1'b1, 32'h2000);
    step("R4", 1'b1, 1'b0, 2'd0, 0, 1'b1, 32'h1800, 1'b1, 32'h1800);
    // R6: user write ignored, probed through next access
    step("R6", 1'b0, 1'b1, 2'd1, 32'h0000_0010, 1'b1, 32'h0800, 1'b0, 0);
    step("R6", 1'b0, 1'b1, 2'd2, 32'h1234_0000, 1'b1, 32'h0800, 1'b1, 32'h100);
    step("R6", 1'b0, 1'b0, 2'd0, 0, 1'b1, 32'h0FFF, 1'b1, 32'h100);
    // R8: both channels fault together with nonzero bounds
    step("R8", 1'b1, 1'b0, 2'd0, 0, 1'b1, 32'h1000, 1'b1, 32'h2000);
    // R3: invalid out-of-range access does not fault
    step("R3", 1'b1, 1'b0, 2'd0, 0, 1'b0, 32'hFFFF_FFFF, 1'b0, 32'hFFFF_FFFF);
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic        sup, wr, fv, dv;
      logic [1:0]  sel;
      logic [31:0] wd, fa, da;
      sup = ($urandom % 4) != 0;
      wr  = ($urandom % 5) == 0;
      sel = 2'($urandom);
      wd  = (sel[0] && ($urandom % 2)) ? ($urandom % 32'h1_0000) : $urandom;
      fv  = ($urandom % 8) != 0;
      dv  = ($urandom % 8) != 0;
      fa  = ($urandom % 2) ? mReg[1] + 32'($urandom % 7) - 32'd3 : $urandom;
      da  = ($urandom % 2) ? mReg[3] + 32'($urandom % 7) - 32'd3 : $urandom;
      step("rand", sup, wr, sel, wd, fv, fa, dv, da);
    end
    idle();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule